// File: doc/BRIEF.md
# Decode Operand Forwarding Unit

This block sits in the decode stage of a five-stage in-order pipeline. It builds the two source operands that are loaded into the execute pipeline register. Each operand normally comes from a register file read port. A result that is still in flight in the execute, memory or write-back stage replaces the read value when its destination register matches the operand's source register.

Operand A also carries the address of the next sequential instruction. Subroutine calls and jumps need that address later in the pipeline, and neither reads a register through port A. For those two instruction codes, operand A takes the next-instruction address instead of any register value.

The block is purely combinational and has no state. Five result buses feed it: the ALU output in execute, and the load data and ALU result in memory and in write-back. Each bus comes with its destination register ID. When several buses name the same register, the one from the youngest instruction wins.

Top module: `opfwd_unit`

## Requirements
- R1: When `icode_i` equals the call code (default 4'h8) or the jump code (default 4'h7), `val_a_o` equals `valp_i`, whatever the forwarding matches are.
- R2: For any other `icode_i`, `val_a_o` is the value of a source bus whose destination ID equals `src_a_i`.
- R3: `val_b_o` is the value of a source bus whose destination ID equals `src_b_i`.
- R4: When several buses match, the priority from highest to lowest is: execute ALU result, memory load data, memory ALU result, write-back load data, write-back ALU result.
- R5: When no bus matches, `val_a_o` equals `rf_a_i` and `val_b_o` equals `rf_b_i`.
- R6: A source ID of 4'hF means "no register" and never matches, even when a destination ID is also 4'hF. The operand then equals the register port value (or `valp_i` under R1).
- R7: `icode_i` has no effect on `val_b_o`.
- R8: The outputs follow the inputs within the same cycle, with no register on any path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| icode_i | input | 4 | Instruction code of the instruction in decode |
| valp_i | input | 64 | Address of the next sequential instruction |
| src_a_i | input | 4 | Source register ID for operand A |
| src_b_i | input | 4 | Source register ID for operand B |
| rf_a_i | input | 64 | Register file read port A value |
| rf_b_i | input | 64 | Register file read port B value |
| exe_alu_val_i | input | 64 | ALU result in execute |
| exe_alu_dst_i | input | 4 | Destination of execute ALU result (4'hF when a conditional move fails) |
| mem_ld_val_i | input | 64 | Data loaded in memory stage |
| mem_ld_dst_i | input | 4 | Destination of memory load data |
| mem_alu_val_i | input | 64 | ALU result held in memory stage |
| mem_alu_dst_i | input | 4 | Destination of memory ALU result |
| wb_ld_val_i | input | 64 | Load data held in write-back |
| wb_ld_dst_i | input | 4 | Destination of write-back load data |
| wb_alu_val_i | input | 64 | ALU result held in write-back |
| wb_alu_dst_i | input | 4 | Destination of write-back ALU result |
| val_a_o | output | 64 | Operand A for the execute register |
| val_b_o | output | 64 | Operand B for the execute register |

## Verification
Immediate assertions are evaluated on every change of the inputs. They check four things: the next-address override for calls and jumps, that a "no register" source never produces a match, the fallback to the register port when nothing matches, and that the chosen value belongs to the lowest-index matching bus. Three behaviours cannot be seen by an assertion inside a single operand path, so only the bench scenarios show them. The first is that the priority order follows pipeline age. The second is that operand B ignores the instruction code. The third is that results appear within the same cycle. The bench shows these by comparing both operands against a reference model under random collisions of register IDs and under directed cases where all buses match.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned NUM_SRC     = 5;
  localparam int unsigned DATA_W_DEF  = 64;
  localparam int unsigned ID_W_DEF    = 4;
  localparam int unsigned ICODE_W_DEF = 4;

  // index order is priority order: lower index = younger writer
  typedef enum int unsigned {
    SRC_EXE_ALU = 0,
    SRC_MEM_LD  = 1,
    SRC_MEM_ALU = 2,
    SRC_WB_LD   = 3,
    SRC_WB_ALU  = 4
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned ID_W = fwd_pkg::ID_W_DEF
) (
  input  logic [ID_W-1:0] src_id_i,
  input  logic [ID_W-1:0] dst_id_i,
  output logic            hit_o
);
  localparam logic [ID_W-1:0] NONE_ID = '1;

  assign hit_o = (src_id_i != NONE_ID) && (src_id_i == dst_id_i);

  always_comb begin
    assert_none_no_hit_R6: assert (!(hit_o && src_id_i == NONE_ID))
      else $error("empty source id produced a hit");
  end
endmodule

// File: rtl/fwd_operand.sv
module fwd_operand #(
  parameter int unsigned DATA_W  = fwd_pkg::DATA_W_DEF,
  parameter int unsigned ID_W    = fwd_pkg::ID_W_DEF,
  parameter int unsigned NUM_SRC = fwd_pkg::NUM_SRC
) (
  input  logic [ID_W-1:0]   src_id_i,
  input  logic [DATA_W-1:0] rf_val_i,
  input  logic [DATA_W-1:0] src_val_i [NUM_SRC],
  input  logic [ID_W-1:0]   src_dst_i [NUM_SRC],
  output logic [DATA_W-1:0] op_val_o
);
  logic [NUM_SRC-1:0] hit_vec;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    fwd_match #(.ID_W(ID_W)) match_i (
      .src_id_i (src_id_i),
      .dst_id_i (src_dst_i[g]),
      .hit_o    (hit_vec[g])
    );
  end

  // walk from oldest to youngest so the youngest hit is written last
  always_comb begin
    op_val_o = rf_val_i;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (hit_vec[k]) op_val_o = src_val_i[k];
    end
  end

  always_comb begin
    assert_rf_fallback_R5: assert ((|hit_vec) || op_val_o == rf_val_i)
      else $error("no hit but operand differs from register port");
  end

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (hit_vec[k] && !seen) begin
        assert_youngest_wins_R4: assert (op_val_o == src_val_i[k])
          else $error("operand not taken from youngest matching source");
        seen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit #(
  parameter int unsigned DATA_W    = fwd_pkg::DATA_W_DEF,
  parameter int unsigned ID_W      = fwd_pkg::ID_W_DEF,
  parameter int unsigned ICODE_W   = fwd_pkg::ICODE_W_DEF,
  parameter logic [ICODE_W-1:0] CALL_CODE = 4'h8,
  parameter logic [ICODE_W-1:0] JUMP_CODE = 4'h7
) (
  input  logic [ICODE_W-1:0] icode_i,
  input  logic [DATA_W-1:0]  valp_i,
  input  logic [ID_W-1:0]    src_a_i,
  input  logic [ID_W-1:0]    src_b_i,
  input  logic [DATA_W-1:0]  rf_a_i,
  input  logic [DATA_W-1:0]  rf_b_i,
  input  logic [DATA_W-1:0]  exe_alu_val_i,
  input  logic [ID_W-1:0]    exe_alu_dst_i,
  input  logic [DATA_W-1:0]  mem_ld_val_i,
  input  logic [ID_W-1:0]    mem_ld_dst_i,
  input  logic [DATA_W-1:0]  mem_alu_val_i,
  input  logic [ID_W-1:0]    mem_alu_dst_i,
  input  logic [DATA_W-1:0]  wb_ld_val_i,
  input  logic [ID_W-1:0]    wb_ld_dst_i,
  input  logic [DATA_W-1:0]  wb_alu_val_i,
  input  logic [ID_W-1:0]    wb_alu_dst_i,
  output logic [DATA_W-1:0]  val_a_o,
  output logic [DATA_W-1:0]  val_b_o
);
  import fwd_pkg::*;

  logic [DATA_W-1:0] src_val [NUM_SRC];
  logic [ID_W-1:0]   src_dst [NUM_SRC];
  logic [DATA_W-1:0] fwd_a;
  logic              use_valp;

  always_comb begin
    src_val[SRC_EXE_ALU] = exe_alu_val_i;  src_dst[SRC_EXE_ALU] = exe_alu_dst_i;
    src_val[SRC_MEM_LD]  = mem_ld_val_i;   src_dst[SRC_MEM_LD]  = mem_ld_dst_i;
    src_val[SRC_MEM_ALU] = mem_alu_val_i;  src_dst[SRC_MEM_ALU] = mem_alu_dst_i;
    src_val[SRC_WB_LD]   = wb_ld_val_i;    src_dst[SRC_WB_LD]   = wb_ld_dst_i;
    src_val[SRC_WB_ALU]  = wb_alu_val_i;   src_dst[SRC_WB_ALU]  = wb_alu_dst_i;
  end

  fwd_operand #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_SRC(NUM_SRC)) opa_i (
    .src_id_i  (src_a_i),
    .rf_val_i  (rf_a_i),
    .src_val_i (src_val),
    .src_dst_i (src_dst),
    .op_val_o  (fwd_a)
  );

  fwd_operand #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_SRC(NUM_SRC)) opb_i (
    .src_id_i  (src_b_i),
    .rf_val_i  (rf_b_i),
    .src_val_i (src_val),
    .src_dst_i (src_dst),
    .op_val_o  (val_b_o)
  );

  // link-style instructions never read port A, so valP rides in its slot
  assign use_valp = (icode_i == CALL_CODE) || (icode_i == JUMP_CODE);
  assign val_a_o  = use_valp ? valp_i : fwd_a;

  always_comb begin
    assert_valp_override_R1: assert (!use_valp || val_a_o == valp_i)
      else $error("call/jump did not select next address");
  end

  always_comb begin
    assert_no_valp_leak_R2: assert (use_valp || val_a_o == fwd_a)
      else $error("operand A bypassed forwarding path");
  end
endmodule

// File: tb/opfwd_unit_tb_top.sv
module opfwd_unit_tb_top;
  localparam int NS = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  icode;
  logic [63:0] valp, rf_a, rf_b;
  logic [3:0]  src_a, src_b;
  logic [63:0] sv [NS];
  logic [3:0]  sd [NS];
  logic [63:0] val_a, val_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  opfwd_unit dut_i (
    .icode_i(icode), .valp_i(valp), .src_a_i(src_a), .src_b_i(src_b),
    .rf_a_i(rf_a), .rf_b_i(rf_b),
    .exe_alu_val_i(sv[0]), .exe_alu_dst_i(sd[0]),
    .mem_ld_val_i(sv[1]),  .mem_ld_dst_i(sd[1]),
    .mem_alu_val_i(sv[2]), .mem_alu_dst_i(sd[2]),
    .wb_ld_val_i(sv[3]),   .wb_ld_dst_i(sd[3]),
    .wb_alu_val_i(sv[4]),  .wb_alu_dst_i(sd[4]),
    .val_a_o(val_a), .val_b_o(val_b)
  );

  function automatic logic [63:0] ref_fwd(input logic [3:0] src, input logic [63:0] rf);
    if (src == 4'hF) return rf;
    for (int k = 0; k < NS; k++) if (sd[k] == src) return sv[k];
    return rf;
  endfunction

  function automatic logic [63:0] ref_a();
    if (icode == 4'h8 || icode == 4'h7) return valp;
    return ref_fwd(src_a, rf_a);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic randomize_inputs(input bit force_ids);
    icode = 4'($urandom % 12);
    valp  = {$urandom, $urandom};
    rf_a  = {$urandom, $urandom};
    rf_b  = {$urandom, $urandom};
    src_a = ($urandom % 6 == 0) ? 4'hF : 4'($urandom % 4);
    src_b = ($urandom % 6 == 0) ? 4'hF : 4'($urandom % 4);
    for (int k = 0; k < NS; k++) begin
      sv[k] = {$urandom, $urandom};
      sd[k] = force_ids ? 4'hF : (($urandom % 5 == 0) ? 4'hF : 4'($urandom % 4));
    end
  endtask

  // drive after posedge, sample at negedge (combinational path, R8)
  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    icode = 4'h0; valp = '0; rf_a = 64'hA; rf_b = 64'hB; src_a = 4'hF; src_b = 4'hF;
    for (int k = 0; k < NS; k++) begin sv[k] = 64'(k + 100); sd[k] = 4'hF; end
    settle();
    check("R5 idle A", val_a, 64'hA);
    check("R5 idle B", val_b, 64'hB);

    // R6: empty source against empty destinations
    @(posedge clk); src_a = 4'hF; src_b = 4'hF; settle();
    check("R6 none-vs-none A", val_a, rf_a);
    check("R6 none-vs-none B", val_b, rf_b);

    // R4: every source names reg 3
    @(posedge clk);
    for (int k = 0; k < NS; k++) sd[k] = 4'h3;
    src_a = 4'h3; src_b = 4'h3; icode = 4'h2; settle();
    check("R4 all match A", val_a, sv[0]);
    check("R4 all match B", val_b, sv[0]);
    // peel off youngest one by one
    for (int j = 0; j < NS - 1; j++) begin
      @(posedge clk); sd[j] = 4'h1; settle();
      check("R4 peel A", val_a, sv[j+1]);
      check("R3 peel B", val_b, sv[j+1]);
    end

    // R1: call and jump override even with a match present
    @(posedge clk); icode = 4'h8; valp = 64'hCAFE_0000_0000_1234; settle();
    check("R1 call", val_a, valp);
    check("R7 call B", val_b, sv[4]);
    @(posedge clk); icode = 4'h7; settle();
    check("R1 jump", val_a, valp);
    check("R7 jump B", val_b, sv[4]);

    // R2: other code forwards
    @(posedge clk); icode = 4'h6; settle();
    check("R2 op fwd", val_a, sv[4]);

    // R5: no match, distinct ids
    @(posedge clk); src_a = 4'h2; src_b = 4'h0; settle();
    check("R5 miss A", val_a, rf_a);
    check("R5 miss B", val_b, rf_b);

    // R6: destination 0xF everywhere, random source
    for (int n = 0; n < 20; n++) begin
      @(posedge clk); randomize_inputs(1'b1); settle();
      check("R6 dst-none A", val_a, ref_a());
      check("R6 dst-none B", val_b, ref_fwd(src_b, rf_b));
    end

    // random mix: R2 R3 R4 R7
    for (int n = 0; n < 400; n++) begin
      @(posedge clk); randomize_inputs(1'b0); settle();
      check("R2 rand A", val_a, ref_a());
      check("R3 rand B", val_b, ref_fwd(src_b, rf_b));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule